// File: doc/BRIEF.md
# Framed Word Serial Master

This block is the master end of a point-to-point serial link that moves 16-bit words between a host processor and a companion audio processor. The master always produces the serial clock. It runs one transaction at a time, writing or reading, and each transaction carries a programmed number of words. One frame-sync output marks write transactions and a second marks read transactions. Each frame sync stays high for the whole transaction and drops while the final bit of the final word is on the wire. This lets the far end tell when the transaction ends without a separate length field.

Firmware sets the direction, the word count, a read-prefetch option and a clock divider, then pulses `start`. From then on it works through a data port, one word per handshake. A write strobe hands the port the next outgoing word. A read strobe consumes the word shown on `rd_data`. The `ready` flag tells firmware when the port can take the next step. With prefetch, the first read word is fetched as soon as the transaction starts. Without prefetch, the first read strobe only launches the first fetch, and the value it returns is meant to be thrown away.

Top module: `fws_master`

## Requirements
- R1: After reset, `sclk`, `sdo`, `tx_fs`, `rx_fs` and `ready` are all 0.
- R2: Write words go out on `sdo` most-significant bit first. `sdo` changes only together with a rising `sclk` and is stable across each falling edge, which is where the receiver samples.
- R3: In a write, `tx_fs` rises with the first rising `sclk` of the first word. It stays high across every bit and every inter-word gap, and is low only for bit 0 of the last word. `rx_fs` stays low throughout a write.
- R4: In a read, `sdi` is sampled on each falling `sclk`, MSB first. The assembled word is presented on `rd_data` while `ready` is high.
- R5: In a read, `rx_fs` follows the same framing rule as `tx_fs` in R3, and `tx_fs` stays low. The two frame syncs are never high together.
- R6: While a word is shifting, `ready` is 0. With `cfg_prefetch`=1, shifting of the first read word begins on the cycle after `start` is accepted. Each later word is fetched by the read strobe that consumes the previous one. N strobes complete an N-word read.
- R7: With `cfg_prefetch`=0, `ready` is 1 on the cycle after `start`, before any clock is produced. The first read strobe only launches the first fetch. N+1 strobes complete an N-word read.
- R8: Every high and every low `sclk` phase within a word lasts `cfg_div`+1 system clock cycles, using the divider value captured at `start`.
- R9: Write and read strobes given while `ready` is 0 have no effect. A `start` with `cfg_len`=0, or a `start` during a transaction, is ignored, and so are changes to the configuration inputs during a transaction.
- R10: When a transaction ends, `ready`, `tx_fs` and `rx_fs` are 0 and `sclk` rests low. A write ends once its last word has shifted out; a read ends on the strobe that consumes the last word.
- R11: During a read, `sdo` is held at 0 whenever `rx_fs` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transaction using the configuration inputs |
| cfg_rd | input | 1 | Direction: 0 write, 1 read |
| cfg_prefetch | input | 1 | For reads, fetch the first word immediately |
| cfg_len | input | LEN_W (8) | Number of words in the transaction; 0 is ignored |
| cfg_div | input | DIV_W (4) | Half-period of `sclk` minus one, in system cycles |
| wr_strobe | input | 1 | Hand `wr_data` to the port (write transactions) |
| wr_data | input | WORD_W (16) | Outgoing word |
| rd_strobe | input | 1 | Consume `rd_data` (read transactions) |
| rd_data | output | WORD_W (16) | Most recently received word |
| ready | output | 1 | Port can accept or supply the next word |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| tx_fs | output | 1 | Write-transaction frame sync |
| rx_fs | output | 1 | Read-transaction frame sync |

## Verification
Writes are driven with a single word and with multi-word bursts of distinct values, including all-ones and a lone low bit. These patterns separate bit-order faults from framing faults on the last word. Reads are run both with and without prefetch, so an off-by-one in the strobe count or a stale first word shows up in the `rd_data` comparison. Several divider settings are used to tell the half-period count apart from a fixed rate. Stray strobes, a zero-length start and a start mid-transaction are injected while a word is shifting, and the scoreboard stream must come through unchanged.

// File: rtl/fws_pkg.sv
// Package: shared types for the framed word serial master.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package fws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } fws_state_e;
endpackage

// File: rtl/fws_divider.sv
// Module: half-period tick generator for the serial clock.
// Emits a one-cycle tick every div_val+1 cycles while run is high.
// Assumes restart is pulsed when a new word begins shifting.
module fws_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Tick when the count reaches the programmed half-period.
    always_comb tick = run && (cnt == div_val);

    // Count system cycles within the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fws_shifter.sv
// Module: one-word serial shift engine.
// On go it raises sclk and drives the MSB. It then alternates falling
// edges (sample sdi) and rising edges (drive the next bit) on each tick.
// Frame sync is raised at go and dropped at the rising edge of bit 0
// of the last word; it holds its level across gaps between words.
// Assumes go is only given while active is low.
module fws_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] go_data,
    input  logic              go_last,
    input  logic              tick,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic              frame,
    output logic              active,
    output logic [WORD_W-1:0] rx_word
);
    localparam int IDX_W = $clog2(WORD_W);

    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] rx;
    logic [WORD_W-1:0] rx_next;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  idx_m1;
    logic              last_q;

    // Next receive value and next bit index.
    always_comb begin
        rx_next = {rx[WORD_W-2:0], sdi};
        idx_m1  = idx - 1'b1;
    end

    // Bit sequencing, serial clock phases and frame level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            rx      <= '0;
            rx_word <= '0;
            idx     <= '0;
            last_q  <= 1'b0;
            sclk    <= 1'b0;
            sdo     <= 1'b0;
            frame   <= 1'b0;
            active  <= 1'b0;
        end else if (go && !active) begin
            sh     <= go_data;
            idx    <= IDX_W'(WORD_W - 1);
            last_q <= go_last;
            sclk   <= 1'b1;
            sdo    <= go_data[WORD_W-1];
            frame  <= 1'b1;
            active <= 1'b1;
        end else if (active && tick) begin
            if (sclk) begin
                sclk <= 1'b0;
                rx   <= rx_next;
                if (idx == '0) begin
                    active  <= 1'b0;
                    rx_word <= rx_next;
                end
            end else begin
                sclk <= 1'b1;
                idx  <= idx_m1;
                sdo  <= sh[idx_m1];
                if (last_q && (idx_m1 == '0)) begin
                    frame <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/fws_ctrl.sv
// Module: transaction controller.
// Captures the configuration on start, counts words, issues go pulses
// to the shift engine and produces the firmware ready handshake.
// Assumes the shift engine reports active from the cycle after go.
module fws_ctrl
    import fws_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 8,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_rd,
    input  logic              cfg_prefetch,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              wr_strobe,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_strobe,
    input  logic              sh_active,
    output logic              go,
    output logic [WORD_W-1:0] go_data,
    output logic              go_last,
    output logic              dir_rd,
    output logic [DIV_W-1:0]  div_q,
    output logic              ready
);
    fws_state_e       state;
    logic [LEN_W-1:0] remain;
    logic             accept_start;

    // Decide handshake, word launch and last-word flag for this cycle.
    always_comb begin
        go           = 1'b0;
        go_data      = '0;
        go_last      = 1'b0;
        ready        = 1'b0;
        accept_start = (state == ST_IDLE) && start && (cfg_len != '0);
        case (state)
            ST_IDLE: begin
                if (accept_start && cfg_rd && cfg_prefetch) begin
                    go      = 1'b1;
                    go_last = (cfg_len == LEN_W'(1));
                end
            end
            ST_WRITE: begin
                ready = (remain != '0) && !sh_active;
                if (ready && wr_strobe) begin
                    go      = 1'b1;
                    go_data = wr_data;
                    go_last = (remain == LEN_W'(1));
                end
            end
            ST_READ: begin
                ready = !sh_active;
                if (ready && rd_strobe && (remain != '0)) begin
                    go      = 1'b1;
                    go_last = (remain == LEN_W'(1));
                end
            end
            default: ;
        endcase
    end

    // Track transaction state and the words still to be launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            remain <= '0;
            dir_rd <= 1'b0;
            div_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept_start) begin
                        dir_rd <= cfg_rd;
                        div_q  <= cfg_div;
                        remain <= go ? cfg_len - 1'b1 : cfg_len;
                        state  <= cfg_rd ? ST_READ : ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (go) begin
                        remain <= remain - 1'b1;
                    end else if ((remain == '0) && !sh_active) begin
                        state <= ST_IDLE;
                    end
                end
                ST_READ: begin
                    if (ready && rd_strobe) begin
                        if (remain != '0) begin
                            remain <= remain - 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fws_master.sv
// Module: framed word serial master, top level.
// Joins the controller, divider and shift engine, and steers the shared
// frame level to the write or read frame-sync pin by direction.
// Assumes a single system clock and synchronous active-low reset.
module fws_master #(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 8,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_rd,
    input  logic              cfg_prefetch,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              wr_strobe,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_data,
    output logic              ready,
    output logic              sclk,
    output logic              sdo,
    input  logic              sdi,
    output logic              tx_fs,
    output logic              rx_fs
);
    logic              go;
    logic [WORD_W-1:0] go_data;
    logic              go_last;
    logic              dir_rd;
    logic [DIV_W-1:0]  div_q;
    logic              sh_active;
    logic              tick;
    logic              frame;

    fws_ctrl #(.WORD_W(WORD_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_rd(cfg_rd),
        .cfg_prefetch(cfg_prefetch), .cfg_len(cfg_len), .cfg_div(cfg_div),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_strobe(rd_strobe),
        .sh_active(sh_active), .go(go), .go_data(go_data), .go_last(go_last),
        .dir_rd(dir_rd), .div_q(div_q), .ready(ready)
    );

    fws_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(sh_active), .restart(go),
        .div_val(div_q), .tick(tick)
    );

    fws_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(go), .go_data(go_data),
        .go_last(go_last), .tick(tick), .sdi(sdi), .sclk(sclk), .sdo(sdo),
        .frame(frame), .active(sh_active), .rx_word(rd_data)
    );

    // Route the frame level to the pin for the current direction.
    always_comb begin
        tx_fs = frame && !dir_rd;
        rx_fs = frame && dir_rd;
    end
endmodule

// File: rtl/fws_master_sva.sv
// Module: protocol checker bound to the framed word serial master.
// Observes pins only; assumes synchronous active-low reset.
module fws_master_sva (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic sdo,
    input logic tx_fs,
    input logic rx_fs,
    input logic ready
);
    assert_data_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> $stable(sdo));

    assert_frame_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tx_fs) || !$stable(rx_fs)) |-> sclk);

    assert_single_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_fs, rx_fs}));

    assert_ready_low_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !ready);

    assert_sdo_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fs |-> !sdo);
endmodule

bind fws_master fws_master_sva u_sva (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdo(sdo),
    .tx_fs(tx_fs), .rx_fs(rx_fs), .ready(ready)
);

// File: tb/fws_master_tb.sv
`timescale 1ns/1ps
module fws_master_tb;
    typedef struct {
        logic [15:0] data;
        bit          last;
        bit          rd;
        int          div;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_rd = 1'b0;
    logic        cfg_prefetch = 1'b0;
    logic [7:0]  cfg_len = '0;
    logic [3:0]  cfg_div = '0;
    logic        wr_strobe = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_strobe = 1'b0;
    logic [15:0] rd_data;
    logic        ready;
    logic        sclk;
    logic        sdo;
    logic        sdi = 1'b0;
    logic        tx_fs;
    logic        rx_fs;

    int checks = 0;
    int fails = 0;
    int words_done = 0;

    item_t       exp_q[$];
    logic [15:0] slv_q[$];

    always #2.5 clk = ~clk;

    fws_master u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_rd(cfg_rd),
        .cfg_prefetch(cfg_prefetch), .cfg_len(cfg_len), .cfg_div(cfg_div),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .ready(ready), .sclk(sclk), .sdo(sdo), .sdi(sdi),
        .tx_fs(tx_fs), .rx_fs(rx_fs)
    );

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Companion device: drives sdi on rising sclk, records rise time.
    int          sl_bit = 15;
    logic [15:0] sl_word = '0;
    time         t_rise = 0;
    always @(posedge sclk) begin
        if (rst_n) begin
            t_rise = $time;
            if (sl_bit == 15) sl_word = (slv_q.size() > 0) ? slv_q.pop_front() : 16'h0;
            sdi <= sl_word[sl_bit];
            sl_bit = (sl_bit == 0) ? 15 : sl_bit - 1;
        end
    end

    // Monitor: samples on falling sclk and compares against the queue.
    int          mon_cnt = 0;
    logic [15:0] mon_sh = '0;
    bit          fs_bad = 0;
    bit          sdo_seen = 0;
    item_t       cur;
    always @(negedge sclk) begin
        if (rst_n) begin
            if (mon_cnt == 0) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "unexpected word", 0, 0);
                    cur = '{16'h0, 1'b0, 1'b0, 0};
                end else begin
                    cur = exp_q.pop_front();
                end
                fs_bad = 0;
                sdo_seen = 0;
                // R8: high phase length in system cycles
                chk(int'(($time - t_rise) / 5) == cur.div + 1, "R8", "half period",
                    int'(($time - t_rise) / 5), cur.div + 1);
            end
            mon_sh = {mon_sh[14:0], sdo};
            if (sdo) sdo_seen = 1;
            begin
                bit exp_fs;
                exp_fs = !(cur.last && mon_cnt == 15);
                if (cur.rd) begin
                    if (rx_fs !== exp_fs || tx_fs !== 1'b0) fs_bad = 1;
                end else begin
                    if (tx_fs !== exp_fs || rx_fs !== 1'b0) fs_bad = 1;
                end
            end
            mon_cnt++;
            if (mon_cnt == 16) begin
                if (cur.rd) begin
                    chk(!sdo_seen, "R11", "sdo during read", sdo_seen, 0);
                    chk(!fs_bad, "R5", "read framing", fs_bad, 0);
                end else begin
                    chk(mon_sh == cur.data, "R2", "write word", mon_sh, cur.data);
                    chk(!fs_bad, "R3", "write framing", fs_bad, 0);
                end
                mon_cnt = 0;
                words_done++;
            end
        end
    end

    task automatic wait_ready();
        do @(negedge clk); while (!ready);
    endtask

    task automatic pulse_start(bit rd, bit pf, int len, int div);
        cfg_rd = rd; cfg_prefetch = pf; cfg_len = 8'(len); cfg_div = 4'(div);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_words(int target);
        while (words_done < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(int div, int n, logic [15:0] base, bit poke);
        int target = words_done + n;
        pulse_start(0, 0, n, div);
        for (int k = 0; k < n; k++) begin
            logic [15:0] w = base + 16'(k) * 16'h1111;
            wait_ready();
            exp_q.push_back('{w, k == n - 1, 1'b0, div});
            wr_data = w; wr_strobe = 1'b1;
            @(negedge clk);
            wr_strobe = 1'b0; wr_data = '0;
            if (poke) begin
                // R9: strobes, start and config changes while shifting
                repeat (2) @(negedge clk);
                wr_data = 16'hDEAD; wr_strobe = 1'b1; rd_strobe = 1'b1;
                cfg_rd = 1'b1; cfg_prefetch = 1'b1; cfg_len = 8'd5; cfg_div = 4'd0;
                start = 1'b1;
                @(negedge clk);
                wr_strobe = 1'b0; rd_strobe = 1'b0; start = 1'b0; wr_data = '0;
            end
        end
        wait_words(target);
        chk(ready == 0 && sclk == 0, "R10", "write end ready/sclk", {ready, sclk}, 0);
        chk(tx_fs == 0 && rx_fs == 0, "R10", "write end frames", {tx_fs, rx_fs}, 0);
    endtask

    task automatic do_read(int div, int n, logic [15:0] base, bit pf);
        int target = words_done + n;
        for (int k = 0; k < n; k++) begin
            logic [15:0] w = base + 16'(k) * 16'h2222;
            slv_q.push_back(w);
            exp_q.push_back('{w, k == n - 1, 1'b1, div});
        end
        pulse_start(1, pf, n, div);
        if (!pf) begin
            chk(ready == 1 && sclk == 0, "R7", "ready before first fetch", {ready, sclk}, 2'b10);
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
        end else begin
            chk(ready == 0, "R6", "prefetch shifting at once", ready, 0);
        end
        for (int k = 0; k < n; k++) begin
            logic [15:0] w = base + 16'(k) * 16'h2222;
            wait_ready();
            chk(rd_data == w, pf ? "R4" : "R7", "read word", rd_data, w);
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
        end
        wait_words(target);
        chk(ready == 0 && sclk == 0 && rx_fs == 0, "R10", "read end",
            {ready, sclk, rx_fs}, 0);
        chk(words_done == target, "R6", "word count", words_done, target);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 0 && sdo == 0 && tx_fs == 0 && rx_fs == 0 && ready == 0,
            "R1", "reset outputs", {sclk, sdo, tx_fs, rx_fs, ready}, 0);

        do_write(0, 1, 16'hA5C3, 0);
        do_write(2, 4, 16'h1234, 1);
        do_read(1, 3, 16'h8421, 1);
        do_read(0, 2, 16'h5A0F, 0);

        // R9: zero-length start ignored
        pulse_start(0, 0, 0, 0);
        repeat (10) @(negedge clk);
        chk(ready == 0 && sclk == 0 && tx_fs == 0, "R9", "zero length ignored",
            {ready, sclk, tx_fs}, 0);

        do_write(5, 2, 16'hFFFF, 0);
        do_write(3, 1, 16'h0001, 0);
        do_read(2, 1, 16'h8001, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule